// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit effective address for the non-indirect addressing modes of a 16-bit processor that extends its address space with bank registers. It is purely combinational. The caller drives a mode code, the instruction operand bytes (up to three), the program bank, data bank, direct-page base, stack pointer, program counter and both index registers. The block returns the address that the memory access or jump should use.

Each mode has its own wrap rule, and that rule is the main point of the block. Direct-page and stack addresses stay inside bank 0. Jump and branch targets stay inside the current program bank. Data-bank and long addresses carry freely into the next bank. Block-move addresses stay inside the bank that their operand byte names. The index inputs are always 16 bits wide. When the core runs with 8-bit index width, the caller zero-extends the index values before driving them.

Top module: `bank_ea_gen`

## Requirements
- R1: In the data-absolute modes (codes 1, 2 and 3), `ea` equals the 24-bit sum of `{dbank, operand[15:0]}` and the index: none for code 1, X for code 2, Y for code 3. A carry out of the low 16 bits increments the bank byte, and the sum wraps modulo 2^24.
- R2: In the direct modes (codes 4, 5 and 6), `ea[15:0]` equals `dpage + operand[7:0]` plus the index (none, X or Y), taken modulo 2^16, and `ea[23:16]` is zero.
- R3: Code 7 returns `operand` unchanged. Code 8 returns `operand + x_idx` modulo 2^24.
- R4: Code 9 (absolute jump) returns `{pbank, operand[15:0]}`.
- R5: Code 10 (short branch) returns `{pbank, pc + sign-extended operand[7:0]}`, with the 16-bit sum wrapping inside the program bank.
- R6: Code 11 (long branch) returns `{pbank, pc + operand[15:0]}` modulo 2^16 in the low half, so a negative displacement works through two's complement.
- R7: Code 12 (push) returns `{8'h00, sp}`. Code 13 (pull) returns `{8'h00, sp + 1}`, with the 16-bit increment wrapping inside bank 0.
- R8: Code 14 (stack relative) returns `{8'h00, sp + operand[7:0]}` modulo 2^16.
- R9: Code 15 (move source) returns `{operand[15:8], x_idx}`. Code 16 (move destination) returns `{operand[7:0], y_idx}`.
- R10: Codes 0 and 17 to 31 return zero whatever the other inputs are.
- R11: Operand bytes that a mode does not use have no effect on `ea`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sel | input | 5 | Addressing-mode code (see requirements) |
| operand | input | 24 | Instruction operand; byte 0 is the first byte after the opcode |
| pbank | input | 8 | Program bank |
| dbank | input | 8 | Data bank |
| dpage | input | 16 | Direct-page base |
| sp | input | 16 | Stack pointer |
| pc | input | 16 | Program counter used as the branch base |
| x_idx | input | 16 | X index, zero-extended by the caller in 8-bit width |
| y_idx | input | 16 | Y index, zero-extended by the caller in 8-bit width |
| ea | output | 24 | Effective address |

## Verification
The assertions check a set of structural invariants every time an input changes. Direct and stack addresses must land in bank 0, and jump and branch targets must carry the program bank. A push must hit `{0, sp}`, the plain long mode must pass the operand through, the move-source address must be the source bank joined with X, and unused codes must give zero. Other results depend on the arithmetic itself: a carry into the bank byte, wrap at FFFF within a bank, a sign-extended displacement, and unused operand bytes having no effect. Only the bench's scenarios can show those. It uses a table of boundary vectors and a sweep that compares the output against an independent model.

// File: rtl/bank_ea_pkg.sv
package bank_ea_pkg;
  localparam int BANK_W = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] M_NONE     = 5'd0;
  localparam logic [MODE_W-1:0] M_ABS      = 5'd1;
  localparam logic [MODE_W-1:0] M_ABS_X    = 5'd2;
  localparam logic [MODE_W-1:0] M_ABS_Y    = 5'd3;
  localparam logic [MODE_W-1:0] M_DIR      = 5'd4;
  localparam logic [MODE_W-1:0] M_DIR_X    = 5'd5;
  localparam logic [MODE_W-1:0] M_DIR_Y    = 5'd6;
  localparam logic [MODE_W-1:0] M_LONG     = 5'd7;
  localparam logic [MODE_W-1:0] M_LONG_X   = 5'd8;
  localparam logic [MODE_W-1:0] M_JMP      = 5'd9;
  localparam logic [MODE_W-1:0] M_REL8     = 5'd10;
  localparam logic [MODE_W-1:0] M_REL16    = 5'd11;
  localparam logic [MODE_W-1:0] M_PUSH     = 5'd12;
  localparam logic [MODE_W-1:0] M_PULL     = 5'd13;
  localparam logic [MODE_W-1:0] M_STK_REL  = 5'd14;
  localparam logic [MODE_W-1:0] M_MOVE_SRC = 5'd15;
  localparam logic [MODE_W-1:0] M_MOVE_DST = 5'd16;

  typedef enum logic [1:0] {IDX_NONE, IDX_X, IDX_Y} idx_src_e;
endpackage

// File: rtl/eag_zero_bank_sum.sv
// Sum of a 16-bit base, an 8-bit offset and a 16-bit addend, wrapped in bank 0.
module eag_zero_bank_sum #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input  logic [WORD_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] addend,
  output logic [ADDR_W-1:0] addr
);
  logic [WORD_W-1:0] low_sum;

  always_comb begin
    low_sum = base + WORD_W'(off) + addend;
    addr    = {{BANK_W{1'b0}}, low_sum};
  end
endmodule

// File: rtl/eag_carry_bank_sum.sv
// Full-width sum: a carry out of the low word propagates into the bank byte.
module eag_carry_bank_sum #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [WORD_W-1:0] low,
  input  logic [WORD_W-1:0] addend,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr = {bank, low} + ADDR_W'(addend);
  end
endmodule

// File: rtl/eag_prog_bank_sum.sv
// Branch target: the displacement is added to the low word only; the bank is kept.
module eag_prog_bank_sum #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  logic [WORD_W-1:0] low_sum;

  always_comb begin
    low_sum = base + disp;
    addr    = {bank, low_sum};
  end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
  import bank_ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [ADDR_W-1:0] operand,
  input  logic [BANK_W-1:0] pbank,
  input  logic [BANK_W-1:0] dbank,
  input  logic [WORD_W-1:0] dpage,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] x_idx,
  input  logic [WORD_W-1:0] y_idx,
  output logic [ADDR_W-1:0] ea
);
  localparam int OFF_W = BANK_W;

  idx_src_e          idx_src;
  logic [WORD_W-1:0] idx_val;
  logic [OFF_W-1:0]  op_lo;
  logic [WORD_W-1:0] op_word;
  logic [OFF_W-1:0]  stk_off;
  logic [WORD_W-1:0] stk_add;
  logic [WORD_W-1:0] long_add;
  logic [WORD_W-1:0] br_disp;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] stk_addr;
  logic [ADDR_W-1:0] abs_addr;
  logic [ADDR_W-1:0] long_addr;
  logic [ADDR_W-1:0] br_addr;

  assign op_lo   = operand[OFF_W-1:0];
  assign op_word = operand[WORD_W-1:0];

  // index source per mode
  always_comb begin
    case (mode_sel)
      M_ABS_X, M_DIR_X, M_LONG_X: idx_src = IDX_X;
      M_ABS_Y, M_DIR_Y:           idx_src = IDX_Y;
      default:                    idx_src = IDX_NONE;
    endcase
  end

  always_comb begin
    case (idx_src)
      IDX_X:   idx_val = x_idx;
      IDX_Y:   idx_val = y_idx;
      default: idx_val = '0;
    endcase
  end

  // stack path: push uses sp, pull sp+1, stack-relative sp+op
  always_comb begin
    stk_off = '0;
    stk_add = '0;
    case (mode_sel)
      M_PULL:    stk_add = WORD_W'(1);
      M_STK_REL: stk_off = op_lo;
      default:   ;
    endcase
  end

  assign long_add = (mode_sel == M_LONG_X) ? x_idx : '0;

  // branch displacement: sign-extended short or full-word long
  always_comb begin
    if (mode_sel == M_REL16) br_disp = op_word;
    else                     br_disp = {{(WORD_W-OFF_W){op_lo[OFF_W-1]}}, op_lo};
  end

  eag_zero_bank_sum #(.BANK_W(BANK_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_dir (
    .base(dpage), .off(op_lo), .addend(idx_val), .addr(dir_addr)
  );

  eag_zero_bank_sum #(.BANK_W(BANK_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_stk (
    .base(sp), .off(stk_off), .addend(stk_add), .addr(stk_addr)
  );

  eag_carry_bank_sum #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_abs (
    .bank(dbank), .low(op_word), .addend(idx_val), .addr(abs_addr)
  );

  eag_carry_bank_sum #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_long (
    .bank(operand[ADDR_W-1:WORD_W]), .low(op_word), .addend(long_add),
    .addr(long_addr)
  );

  eag_prog_bank_sum #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_br (
    .bank(pbank), .base(pc), .disp(br_disp), .addr(br_addr)
  );

  // final selection
  always_comb begin
    case (mode_sel)
      M_ABS, M_ABS_X, M_ABS_Y:   ea = abs_addr;
      M_DIR, M_DIR_X, M_DIR_Y:   ea = dir_addr;
      M_LONG, M_LONG_X:          ea = long_addr;
      M_JMP:                     ea = {pbank, op_word};
      M_REL8, M_REL16:           ea = br_addr;
      M_PUSH, M_PULL, M_STK_REL: ea = stk_addr;
      M_MOVE_SRC:                ea = {operand[WORD_W-1:OFF_W], x_idx};
      M_MOVE_DST:                ea = {op_lo, y_idx};
      default:                   ea = '0;
    endcase
  end
endmodule

// File: rtl/bank_ea_gen_chk.sv
module bank_ea_gen_chk
  import bank_ea_pkg::*;
(
  input logic [MODE_W-1:0] mode_sel,
  input logic [ADDR_W-1:0] operand,
  input logic [BANK_W-1:0] pbank,
  input logic [WORD_W-1:0] sp,
  input logic [WORD_W-1:0] x_idx,
  input logic [ADDR_W-1:0] ea
);
  always_comb begin
    // R2 R7 R8
    bank0_chk: assert (!(mode_sel inside {M_DIR, M_DIR_X, M_DIR_Y, M_PUSH, M_PULL, M_STK_REL})
                       || ea[ADDR_W-1:WORD_W] == '0)
      else $error("bank-0 mode left bank 0");
    // R4 R5 R6
    pbank_chk: assert (!(mode_sel inside {M_JMP, M_REL8, M_REL16})
                       || ea[ADDR_W-1:WORD_W] == pbank)
      else $error("program-bank target left the bank");
    // R7
    push_chk: assert (mode_sel != M_PUSH || ea == {{BANK_W{1'b0}}, sp})
      else $error("push address wrong");
    // R3
    long_chk: assert (mode_sel != M_LONG || ea == operand)
      else $error("long address differs from operand");
    // R9
    move_chk: assert (mode_sel != M_MOVE_SRC
                      || ea == {operand[WORD_W-1:BANK_W], x_idx})
      else $error("move source address wrong");
    // R10
    unused_chk: assert (!(mode_sel == M_NONE || mode_sel > M_MOVE_DST) || ea == '0)
      else $error("unused code gave nonzero address");
  end
endmodule

bind bank_ea_gen bank_ea_gen_chk u_chk (
  .mode_sel(mode_sel), .operand(operand), .pbank(pbank), .sp(sp),
  .x_idx(x_idx), .ea(ea)
);

// File: tb/sim_bank_ea_gen.sv
module sim_bank_ea_gen;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 20;
  localparam int NSWEEP  = 400;

  typedef struct packed {
    logic [4:0]  mode;
    logic [23:0] op;
    logic [7:0]  pb;
    logic [7:0]  db;
    logic [15:0] dp;
    logic [15:0] s;
    logic [15:0] pcv;
    logic [15:0] xv;
    logic [15:0] yv;
    logic [23:0] exp;
  } vec_t;

  // mode, operand, pbank, dbank, dpage, sp, pc, x, y, expected
  localparam vec_t VEC [NVEC] = '{
    '{5'd1,  24'h991234, 8'h00, 8'h12, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 24'h121234}, // R1 R11
    '{5'd2,  24'h00FFF0, 8'h00, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 16'h0020, 16'h0000, 24'h000010}, // R1 bank FF overflow
    '{5'd3,  24'h008000, 8'h00, 8'h05, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h9000, 24'h061000}, // R1 carry
    '{5'd4,  24'hAB0010, 8'h00, 8'h33, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 24'h00000F}, // R2 R11
    '{5'd5,  24'h0000FF, 8'h00, 8'h33, 16'h1200, 16'h0000, 16'h0000, 16'hFF00, 16'h0000, 24'h0011FF}, // R2
    '{5'd6,  24'h000002, 8'h00, 8'h33, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0003, 24'h000105}, // R2
    '{5'd7,  24'hABCDEF, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h1111, 16'h0000, 24'hABCDEF}, // R3
    '{5'd8,  24'hFFFFF0, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0020, 16'h0000, 24'h000010}, // R3
    '{5'd9,  24'hFF4567, 8'h7E, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 24'h7E4567}, // R4 R11
    '{5'd10, 24'h000080, 8'h03, 8'h00, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 16'h0000, 24'h03FF90}, // R5 negative
    '{5'd10, 24'h00007F, 8'h03, 8'h00, 16'h0000, 16'h0000, 16'hFFF0, 16'h0000, 16'h0000, 24'h03006F}, // R5 wrap
    '{5'd11, 24'h000100, 8'h03, 8'h00, 16'h0000, 16'h0000, 16'hFF80, 16'h0000, 16'h0000, 24'h030080}, // R6
    '{5'd11, 24'h00FFFE, 8'h40, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 24'h40FFFF}, // R6 negative
    '{5'd12, 24'hFFFFFF, 8'h00, 8'h00, 16'h0000, 16'h01FF, 16'h0000, 16'h0000, 16'h0000, 24'h0001FF}, // R7
    '{5'd13, 24'h000000, 8'h00, 8'h00, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 24'h000000}, // R7 wrap
    '{5'd14, 24'h000005, 8'h00, 8'h00, 16'h0000, 16'hFFFE, 16'h0000, 16'h0000, 16'h0000, 24'h000003}, // R8
    '{5'd15, 24'h007F12, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'hABCD, 16'h1234, 24'h7FABCD}, // R9
    '{5'd16, 24'h007F12, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'hABCD, 16'h1234, 24'h121234}, // R9
    '{5'd20, 24'hFFFFFF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 24'h000000}, // R10
    '{5'd0,  24'h123456, 8'h11, 8'h22, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 24'h000000}  // R10
  };

  logic        clk;
  logic        rst_n;
  logic [4:0]  mode_sel;
  logic [23:0] operand;
  logic [7:0]  pbank, dbank;
  logic [15:0] dpage, sp, pc, x_idx, y_idx;
  logic [23:0] ea;
  int          total;
  int          bad;
  bit          done;

  bank_ea_gen u0 (
    .mode_sel(mode_sel), .operand(operand), .pbank(pbank), .dbank(dbank),
    .dpage(dpage), .sp(sp), .pc(pc), .x_idx(x_idx), .y_idx(y_idx), .ea(ea)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic string req_of(input logic [4:0] m);
    case (m)
      5'd1, 5'd2, 5'd3:   return "R1";
      5'd4, 5'd5, 5'd6:   return "R2";
      5'd7, 5'd8:         return "R3";
      5'd9:               return "R4";
      5'd10:              return "R5";
      5'd11:              return "R6";
      5'd12, 5'd13:       return "R7";
      5'd14:              return "R8";
      5'd15, 5'd16:       return "R9";
      default:            return "R10";
    endcase
  endfunction

  // independent model written from the requirements
  function automatic logic [23:0] model(input vec_t v);
    logic [15:0] lo;
    case (v.mode)
      5'd1:  return {v.db, v.op[15:0]};
      5'd2:  return {v.db, v.op[15:0]} + {8'h0, v.xv};
      5'd3:  return {v.db, v.op[15:0]} + {8'h0, v.yv};
      5'd4:  begin lo = v.dp + {8'h0, v.op[7:0]};        return {8'h0, lo}; end
      5'd5:  begin lo = v.dp + {8'h0, v.op[7:0]} + v.xv; return {8'h0, lo}; end
      5'd6:  begin lo = v.dp + {8'h0, v.op[7:0]} + v.yv; return {8'h0, lo}; end
      5'd7:  return v.op;
      5'd8:  return v.op + {8'h0, v.xv};
      5'd9:  return {v.pb, v.op[15:0]};
      5'd10: begin lo = v.pcv + {{8{v.op[7]}}, v.op[7:0]}; return {v.pb, lo}; end
      5'd11: begin lo = v.pcv + v.op[15:0]; return {v.pb, lo}; end
      5'd12: return {8'h0, v.s};
      5'd13: begin lo = v.s + 16'd1; return {8'h0, lo}; end
      5'd14: begin lo = v.s + {8'h0, v.op[7:0]}; return {8'h0, lo}; end
      5'd15: return {v.op[15:8], v.xv};
      5'd16: return {v.op[7:0], v.yv};
      default: return 24'h0;
    endcase
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode_sel = v.mode; operand = v.op; pbank = v.pb; dbank = v.db;
    dpage = v.dp; sp = v.s; pc = v.pcv; x_idx = v.xv; y_idx = v.yv;
    #(CLK_PER/4);
  endtask

  task automatic check(input string req, input logic [23:0] expv);
    total++;
    if (ea !== expv) begin
      bad++;
      $display("FAIL %s mode=%0d got=%06h exp=%06h", req, mode_sel, ea, expv);
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0;
    mode_sel = '0; operand = '0; pbank = '0; dbank = '0;
    dpage = '0; sp = '0; pc = '0; x_idx = '0; y_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs give zero (R10)
    check("R10", 24'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      check(req_of(VEC[i].mode), VEC[i].exp);
    end

    // directed: only byte 0 used by short branch, upper bytes ignored (R11)
    begin
      vec_t v;
      v = '{5'd10, 24'hFFFF02, 8'h09, 8'h00, 16'h0, 16'h0, 16'h1000, 16'h0, 16'h0, 24'h0};
      apply(v);
      check("R11", 24'h091002);
      v = '{5'd14, 24'hEEEE00, 8'h00, 8'h00, 16'h0, 16'h2000, 16'h0, 16'h0, 16'h0, 24'h0};
      apply(v);
      check("R11", 24'h002000);
      v = '{5'd16, 24'hFF0001, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'hFFFF, 24'h0};
      apply(v);
      check("R9", 24'h01FFFF);
    end

    // sweep against the model over all codes
    for (int k = 0; k < NSWEEP; k++) begin
      vec_t v;
      v.mode = 5'(k % 32);
      v.op   = 24'($urandom); v.pb = 8'($urandom); v.db = 8'($urandom);
      v.dp   = 16'($urandom); v.s  = 16'($urandom); v.pcv = 16'($urandom);
      v.xv   = 16'($urandom); v.yv = 16'($urandom);
      if (k % 7 == 0) begin v.dp = 16'hFFFF; v.s = 16'hFFFF; v.db = 8'hFF; v.xv = 16'hFFFF; end
      v.exp  = '0;
      apply(v);
      check(req_of(v.mode), model(v));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule